// File: doc/BRIEF.md
# Three-Step Code Lock Controller

This block is a clocked state machine that releases a door once a user keys in a fixed three-number code in the right order. Each number is placed on a small value input and then confirmed with a press strobe. The lock compares every confirmed number against the digit expected at its current step. It advances on a match and drops into a rejection state on any mismatch.

The door-release output and the rejection flag are both sticky. Once the door is released, or once a wrong number has been seen, only the synchronous reset returns the lock to its waiting state. A press that stays high for several cycles is taken as one entry, because the strobe is edge-detected inside the block. The three code digits are parameters fixed at elaboration.

Top module: `lock_top`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, the lock returns to waiting for the first digit, and after that edge `open_o` and `err_o` are both 0.
- R2: Three presses whose digits equal FIRST_CODE, SECOND_CODE and THIRD_CODE in that order set `open_o` to 1 at the clock edge that samples the third press. After only one or two such presses `open_o` stays 0.
- R3: An entry is taken only at the first cycle in which `press_i` is high after a cycle in which it was low. Further cycles of the same press add no entry, even if `digit_i` changes during them.
- R4: While `press_i` is low, changes on `digit_i` have no effect on `open_o` or `err_o`.
- R5: An entry whose digit differs from the one expected at the current step sets `err_o` to 1 at the clock edge that samples it, and leaves `open_o` at 0. This holds for a wrong first, second or third digit.
- R6: While `err_o` is 1, further entries, including the full correct code, are ignored, and `err_o` stays 1 until reset.
- R7: While `open_o` is 1, further entries of any value are ignored, and `open_o` stays 1 until reset.
- R8: A reset taken from any of the five states (waiting, one digit accepted, two digits accepted, released, rejected) leaves the lock waiting, and a fresh correct code then opens it.
- R9: `open_o` and `err_o` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; everything changes on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| digit_i | input | DIGIT_W | Number being entered |
| press_i | input | 1 | Entry strobe; its rising edge confirms `digit_i` |
| open_o | output | 1 | Door released (registered) |
| err_o | output | 1 | Wrong entry seen, lock rejected (registered) |

## Verification
The bench builds the lock with the default 4-bit digit width but overrides the code to 7, 7, 12. With the first two digits equal, a repeated press of the same value is a correct second entry rather than a stale one, so an edge detector that wrongly swallows a second press of the same digit becomes visible. The 12 places a digit with its top bit set in the code, so a compare that drops the upper bits of `digit_i` shows up. Random digits are weighted toward the expected one, which lets random runs reach the released state as well as every rejection point.

// File: rtl/lock_pkg.sv
package lock_pkg;

    localparam int unsigned NUM_STEPS = 3;
    localparam int unsigned STEP_W    = 2;

    typedef enum logic [2:0] {
        ST_WAIT  = 3'd0,
        ST_ONE   = 3'd1,
        ST_TWO   = 3'd2,
        ST_OPEN  = 3'd3,
        ST_REJ   = 3'd4
    } lock_state_e;

    typedef struct packed {
        logic door_open;
        logic rejected;
    } lock_flags_t;

    // Which code position the lock is waiting for in a given state.
    function automatic logic [STEP_W-1:0] step_of(lock_state_e s);
        case (s)
            ST_ONE:  return 2'd1;
            ST_TWO:  return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    // Next state from the current one, an entry pulse and the match result.
    function automatic lock_state_e advance(lock_state_e cur, logic entry, logic hit);
        if (!entry) return cur;
        case (cur)
            ST_WAIT: return hit ? ST_ONE  : ST_REJ;
            ST_ONE:  return hit ? ST_TWO  : ST_REJ;
            ST_TWO:  return hit ? ST_OPEN : ST_REJ;
            default: return cur;
        endcase
    endfunction

    function automatic lock_flags_t decode(lock_state_e s);
        lock_flags_t f;
        f.door_open = (s == ST_OPEN);
        f.rejected  = (s == ST_REJ);
        return f;
    endfunction

endpackage

// File: rtl/lock_press_edge.sv
module lock_press_edge (
    input  logic clk_i,
    input  logic rst_i,
    input  logic press_i,
    output logic entry_o
);
    logic prev_q;

    // The previous level is tracked during reset too, so a press still
    // held when reset drops is not counted as a new entry.
    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= press_i;
        else       prev_q <= press_i;
    end

    assign entry_o = press_i & ~prev_q & ~rst_i;
endmodule

// File: rtl/lock_code_match.sv
module lock_code_match
    import lock_pkg::*;
#(
    parameter int unsigned DIGIT_W = 4,
    parameter logic [NUM_STEPS*DIGIT_W-1:0] CODE_VEC = '0
) (
    input  logic [DIGIT_W-1:0] digit_i,
    input  logic [STEP_W-1:0]  step_i,
    output logic               hit_o
);
    localparam int unsigned SLOTS = 1 << STEP_W;

    logic [SLOTS-1:0] hits;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (i < NUM_STEPS) begin : g_used
            assign hits[i] = (digit_i == CODE_VEC[i*DIGIT_W +: DIGIT_W]);
        end else begin : g_spare
            assign hits[i] = 1'b0;
        end
    end

    assign hit_o = hits[step_i];
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
    import lock_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               entry_i,
    input  logic               hit_i,
    output logic [STEP_W-1:0]  step_o,
    output lock_flags_t        flags_o
);
    lock_state_e state_q, state_d;

    always_comb begin
        state_d = advance(state_q, entry_i, hit_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_WAIT;
            flags_o <= '0;
        end else begin
            state_q <= state_d;
            flags_o <= decode(state_d);
        end
    end

    assign step_o = step_of(state_q);
endmodule

// File: rtl/lock_top.sv
module lock_top
    import lock_pkg::*;
#(
    parameter int unsigned         DIGIT_W     = 4,
    parameter logic [DIGIT_W-1:0]  FIRST_CODE  = 4'd3,
    parameter logic [DIGIT_W-1:0]  SECOND_CODE = 4'd9,
    parameter logic [DIGIT_W-1:0]  THIRD_CODE  = 4'd5
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [DIGIT_W-1:0] digit_i,
    input  logic               press_i,
    output logic               open_o,
    output logic               err_o
);
    localparam logic [NUM_STEPS*DIGIT_W-1:0] CODE_VEC = {THIRD_CODE, SECOND_CODE, FIRST_CODE};

    logic              entry;
    logic              hit;
    logic [STEP_W-1:0] step;
    lock_flags_t       flags;

    lock_press_edge u_edge (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .press_i (press_i),
        .entry_o (entry)
    );

    lock_code_match #(
        .DIGIT_W  (DIGIT_W),
        .CODE_VEC (CODE_VEC)
    ) u_match (
        .digit_i (digit_i),
        .step_i  (step),
        .hit_o   (hit)
    );

    lock_fsm u_fsm (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .entry_i (entry),
        .hit_i   (hit),
        .step_o  (step),
        .flags_o (flags)
    );

    assign open_o = flags.door_open;
    assign err_o  = flags.rejected;
endmodule

// File: rtl/lock_chk.sv
module lock_chk (
    input logic clk_i,
    input logic rst_i,
    input logic press_i,
    input logic open_o,
    input logic err_o
);
    // R1
    reset_clears_chk: assert property (@(posedge clk_i) rst_i |=> (!open_o && !err_o));

    // R9
    flags_exclusive_chk: assert property (@(posedge clk_i) disable iff (rst_i) !(open_o && err_o));

    // R6
    rej_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i) err_o |=> err_o);

    // R7
    open_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i) open_o |=> open_o);

    // R4
    idle_press_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !press_i |=> ($stable(open_o) && $stable(err_o)));

    // R2
    open_by_press_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(open_o) |-> $past(press_i));
endmodule

bind lock_top lock_chk u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .press_i (press_i),
    .open_o  (open_o),
    .err_o   (err_o)
);

// File: tb/lock_top_tb_top.sv
module lock_top_tb_top;
    localparam int unsigned W = 4;
    localparam logic [W-1:0] C0 = 4'd7;
    localparam logic [W-1:0] C1 = 4'd7;
    localparam logic [W-1:0] C2 = 4'd12;

    logic         clk = 1'b0;
    logic         rst_i;
    logic [W-1:0] digit_i;
    logic         press_i;
    logic         open_o;
    logic         err_o;

    always #2 clk = ~clk;

    lock_top #(.DIGIT_W(W), .FIRST_CODE(C0), .SECOND_CODE(C1), .THIRD_CODE(C2)) dut_i (
        .clk_i (clk), .rst_i (rst_i), .digit_i (digit_i),
        .press_i (press_i), .open_o (open_o), .err_o (err_o)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    string tag      = "R1";

    // Bench reference: step 0..2 waiting, 3 released, 4 rejected.
    int m_step     = 0;
    bit m_prev     = 1'b0;

    function automatic logic [W-1:0] want(int s);
        return (s == 0) ? C0 : (s == 1) ? C1 : C2;
    endfunction

    function automatic int model_next(int s, bit rst, bit edge_seen, logic [W-1:0] d);
        if (rst) return 0;
        if (!edge_seen || s >= 3) return s;
        return (d == want(s)) ? s + 1 : 4;
    endfunction

    task automatic check(string req, logic act, logic exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Called at a falling edge: drive, cross one rising edge, compare.
    task automatic tick(bit rst, bit prs, logic [W-1:0] d);
        bit edge_seen;
        rst_i = rst; press_i = prs; digit_i = d;
        @(posedge clk);
        edge_seen = prs && !m_prev && !rst;
        m_step = model_next(m_step, rst, edge_seen, d);
        m_prev = prs;
        @(negedge clk);
        check(tag, open_o, (m_step == 3), "open_o");
        check(tag, err_o,  (m_step == 4), "err_o");
        check("R9", open_o & err_o, 1'b0, "open&err");
    endtask

    task automatic enter(logic [W-1:0] d, int hold);
        for (int i = 0; i < hold; i++) tick(1'b0, 1'b1, d);
        tick(1'b0, 1'b0, d);
    endtask

    task automatic do_reset();
        tick(1'b1, 1'b0, '0);
        tick(1'b0, 1'b0, '0);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail + 1, n_checks + 1);
        $finish;
    end

    initial begin
        rst_i = 1'b1; press_i = 1'b0; digit_i = '0;
        @(negedge clk);
        tag = "R1"; tick(1'b1, 1'b0, '0); tick(1'b1, 1'b0, '0); tick(1'b0, 1'b0, '0);

        // R2: full code with gaps; closed after two digits
        tag = "R2";
        enter(C0, 1); enter(C1, 1);
        check("R2", open_o, 1'b0, "open after two digits");
        tick(1'b0, 1'b0, 4'd1);
        enter(C2, 1);
        check("R2", open_o, 1'b1, "open after three digits");
        do_reset();

        // R3: long press with changing value counts once
        tag = "R3";
        tick(1'b0, 1'b1, C0); tick(1'b0, 1'b1, 4'd0); tick(1'b0, 1'b1, 4'd15);
        tick(1'b0, 1'b0, 4'd0);
        check("R3", err_o, 1'b0, "held press rejected");
        enter(C1, 3); enter(C2, 2);
        check("R3", open_o, 1'b1, "open after held presses");
        do_reset();

        // R4: value wiggles without press
        tag = "R4";
        for (int v = 0; v < 16; v++) tick(1'b0, 1'b0, 4'(v));
        enter(C0, 1);
        for (int v = 15; v >= 0; v--) tick(1'b0, 1'b0, 4'(v));
        check("R4", err_o, 1'b0, "err after idle wiggle");
        do_reset();

        // R5: wrong first, second, third digit
        tag = "R5";
        enter(4'd6, 1); check("R5", err_o, 1'b1, "wrong first");
        do_reset();
        enter(C0, 1); enter(4'd12, 1); check("R5", err_o, 1'b1, "wrong second");
        do_reset();
        enter(C0, 1); enter(C1, 1); enter(4'd4, 1);
        check("R5", err_o, 1'b1, "wrong third");
        check("R5", open_o, 1'b0, "open after wrong third");

        // R6: rejected lock ignores the correct code
        tag = "R6";
        enter(C0, 1); enter(C1, 1); enter(C2, 1);
        check("R6", err_o, 1'b1, "err kept in reject");
        check("R6", open_o, 1'b0, "open from reject");
        do_reset();

        // R7: released lock ignores any entries
        tag = "R7";
        enter(C0, 1); enter(C1, 1); enter(C2, 1);
        enter(4'd0, 1); enter(C0, 2); enter(4'd15, 1);
        check("R7", open_o, 1'b1, "open kept");
        check("R7", err_o, 1'b0, "err while open");

        // R8: reset from every state, then a fresh code opens
        tag = "R8";
        for (int s = 0; s < 5; s++) begin
            do_reset();
            if (s == 4) enter(4'd1, 1);
            else for (int k = 0; k < s; k++) enter(want(k), 1);
            tick(1'b1, 1'b0, '0);
            check("R8", open_o | err_o, 1'b0, "flags after reset");
            tick(1'b0, 1'b0, '0);
            enter(C0, 1); enter(C1, 1); enter(C2, 1);
            check("R8", open_o, 1'b1, "open after reset");
        end

        // Random mix, R2 R3 R5 R6 R7
        tag = "R2,R3,R5,R6,R7 random";
        void'($urandom(32'd2024));
        do_reset();
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom_range(0, 19));
            if (r == 0) tick(1'b1, 1'b0, 4'($urandom_range(0, 15)));
            else if (r < 4) tick(1'b0, 1'b0, 4'($urandom_range(0, 15)));
            else if (r < 14) enter((m_step < 3) ? want(m_step) : 4'($urandom_range(0, 15)),
                                   int'($urandom_range(1, 3)));
            else enter(4'($urandom_range(0, 15)), int'($urandom_range(1, 2)));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule